// File: doc/BRIEF.md
# UDP Stream Packetizer

This block turns an unbroken stream of 32-bit sample words from an external converter into a train of IPv4/UDP datagrams. The datagrams are ready for the input arbiter of a packet-processing pipeline. Every datagram opens with a 20-byte IPv4 header and an 8-byte UDP header. Two 32-bit words follow: a cycle-count timestamp and a per-datagram sequence number. After them come a fixed number of sample words, set by a byte-length setting. The output bus carries one 32-bit word per beat, most significant byte first, and marks the first and last beat of each datagram.

Addresses, ports, payload length and an enable bit come in as configuration inputs. The block copies them at the start of each datagram, so a change made while a datagram is in flight only affects the next one. Back-pressure flows straight through: while the output is stalled, the sample stream is stalled too, and no word is dropped or duplicated. With the enable held high, datagrams follow one another without idle cycles.

Top module: `udp_stream_packetizer`

## Requirements
- R1: During reset and after it, with `cfg_enable` low, `out_valid` and `in_ready` stay 0. The first datagram after reset carries sequence number 0.
- R2: Beat 0 begins with byte 0x45 (version 4, header length 5) and a zero service byte. Beat 1 holds the identification field, equal to the low 16 bits of the sequence number, and then 16 zero bits (no DF, offset 0). Beat 2 begins with TTL 64 and protocol 17.
- R3: The low half of beat 2 is the IPv4 header checksum. Summing the ten 16-bit halves of beats 0 to 4 with end-around carry and inverting the result gives that field.
- R4: The low half of beat 0 (IP total length) equals P+36, where P is `cfg_payload_bytes` with its two low bits cleared. The high half of beat 6 (UDP length) equals P+16, and the two low bits of `cfg_payload_bytes` have no effect.
- R5: Beat 3 carries the source address and beat 4 the destination address. Beat 5 carries {source port, destination port}. The low half of beat 6 (UDP checksum) is zero.
- R6: Beat 7 carries a free-running cycle counter. The counter reads 0 in the first cycle after reset is released and rises by 1 every clock. Beat 7 holds its value in the cycle when beat 0 of that datagram was accepted.
- R7: Beat 8 carries a 32-bit sequence number that rises by one for every datagram completed.
- R8: Beats 9 onward carry P/4 input words in arrival order. `out_sop` marks beat 0 and `out_eop` the last beat. When P is below 4, `out_eop` marks beat 8.
- R9: `in_ready` is high only while payload is moving and `out_ready` is high. It is never high during header beats or while `out_ready` is low. Every accepted input word appears on the output.
- R10: `cfg_enable` is sampled only when idle and at the last beat of a datagram. Dropping it mid-datagram lets that datagram finish, and then the output goes quiet. Configuration changes made mid-datagram apply only from the next datagram.
- R11: With `cfg_enable` held high and `out_ready` high, beat 0 of the next datagram is presented in the cycle right after the last beat of the previous one is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_enable | input | 1 | Start/continue packetizing at datagram boundaries |
| cfg_src_ip | input | 32 | IPv4 source address |
| cfg_dst_ip | input | 32 | IPv4 destination address |
| cfg_src_port | input | 16 | UDP source port |
| cfg_dst_port | input | 16 | UDP destination port |
| cfg_payload_bytes | input | 16 | Sample payload length in bytes (low 2 bits ignored) |
| in_data | input | 32 | Sample word |
| in_valid | input | 1 | Sample word present |
| in_ready | output | 1 | Sample word taken this cycle when valid |
| out_data | output | 32 | Datagram word, big-endian |
| out_valid | output | 1 | Datagram word present |
| out_ready | input | 1 | Downstream takes the word |
| out_sop | output | 1 | First beat of a datagram |
| out_eop | output | 1 | Last beat of a datagram |

## Verification
The hardest state to reach is a stall that falls on the header-to-payload handover or on the first header beat. The first case tests whether stream words are held back correctly. The second decides which counter value the timestamp captures. The stimulus gets there by driving `out_ready` and `in_valid` from independent pseudo-random sequences over several datagrams. Separate runs cover a zero-length payload and an unaligned length. A further run changes addresses and ports right after a start-of-packet, then drops the enable during the following header, so the snapshot and stop-at-boundary paths are both exercised.

// File: rtl/udp_pkt_pkg.sv
// Shared constants and types for the UDP stream packetizer.
// Assumes a 32-bit datapath with big-endian byte order on the wire.
package udp_pkt_pkg;

    localparam int WORD_W       = 32;
    localparam int LEN_W        = 16;
    localparam int BEAT_IDX_W   = 4;
    localparam int HDR_BEATS    = 9;      // 5 IP + 2 UDP + timestamp + sequence
    localparam logic [7:0] IP_VER_IHL   = 8'h45;
    localparam logic [7:0] IP_TOS       = 8'h00;
    localparam logic [7:0] IP_TTL       = 8'd64;
    localparam logic [7:0] IP_PROTO_UDP = 8'd17;
    localparam logic [15:0] IP_LEN_OVH  = 16'd36;  // IP + UDP headers + ts + seq
    localparam logic [15:0] UDP_LEN_OVH = 16'd16;  // UDP header + ts + seq

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_PAY  = 2'd2
    } pkt_state_e;

    typedef struct packed {
        logic [31:0]      src_ip;
        logic [31:0]      dst_ip;
        logic [15:0]      src_port;
        logic [15:0]      dst_port;
        logic [LEN_W-1:0] pay_bytes;
    } pkt_cfg_t;

endpackage

// File: rtl/udp_pkt_cycle_counter.sv
// Free-running cycle counter used as the datagram timestamp source.
// Assumes wrap-around at 2**CNT_W is acceptable to the receiver.
module udp_pkt_cycle_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count
);

    // Count every clock from zero after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/udp_pkt_ip_csum.sv
// IPv4 header checksum over the fixed header image built by the packetizer.
// Assumes the service byte, flags and fragment offset are all zero.
module udp_pkt_ip_csum
    import udp_pkt_pkg::*;
(
    input  logic [15:0] total_len,
    input  logic [15:0] ident,
    input  logic [31:0] src_ip,
    input  logic [31:0] dst_ip,
    output logic [15:0] csum
);

    localparam int ACC_W = 20;

    logic [ACC_W-1:0] acc;
    logic [16:0]      fold1;
    logic [15:0]      fold2;

    // Sum the header halves, fold the carries twice, then invert.
    always_comb begin
        acc = ACC_W'({IP_VER_IHL, IP_TOS})
            + ACC_W'(total_len)
            + ACC_W'(ident)
            + ACC_W'({IP_TTL, IP_PROTO_UDP})
            + ACC_W'(src_ip[31:16]) + ACC_W'(src_ip[15:0])
            + ACC_W'(dst_ip[31:16]) + ACC_W'(dst_ip[15:0]);
        fold1 = 17'(acc[15:0]) + 17'(acc[ACC_W-1:16]);
        fold2 = fold1[15:0] + 16'(fold1[16]);
        csum  = ~fold2;
    end

endmodule

// File: rtl/udp_pkt_hdr_mux.sv
// Selects the header word for a given header beat index.
// Assumes beat indices 0..HDR_BEATS-1; other indices yield zero.
module udp_pkt_hdr_mux
    import udp_pkt_pkg::*;
(
    input  logic [BEAT_IDX_W-1:0] beat,
    input  pkt_cfg_t              cfg,
    input  logic [15:0]           total_len,
    input  logic [15:0]           udp_len,
    input  logic [15:0]           ident,
    input  logic [15:0]           csum,
    input  logic [31:0]           stamp,
    input  logic [31:0]           seq,
    output logic [WORD_W-1:0]     word
);

    // Map the beat index onto the IPv4/UDP/prefix word layout.
    always_comb begin
        unique case (beat)
            4'd0:    word = {IP_VER_IHL, IP_TOS, total_len};
            4'd1:    word = {ident, 16'h0000};
            4'd2:    word = {IP_TTL, IP_PROTO_UDP, csum};
            4'd3:    word = cfg.src_ip;
            4'd4:    word = cfg.dst_ip;
            4'd5:    word = {cfg.src_port, cfg.dst_port};
            4'd6:    word = {udp_len, 16'h0000};
            4'd7:    word = stamp;
            4'd8:    word = seq;
            default: word = '0;
        endcase
    end

endmodule

// File: rtl/udp_stream_packetizer.sv
// Frames a continuous 32-bit sample stream into IPv4/UDP datagrams.
// Each datagram: 9 header beats (IP, UDP, timestamp, sequence) then
// cfg_payload_bytes/4 sample words. Configuration is captured per datagram.
// Assumes the upstream holds in_data stable while in_valid && !in_ready.
module udp_stream_packetizer
    import udp_pkt_pkg::*;
#(
    parameter int TS_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic [31:0]       cfg_src_ip,
    input  logic [31:0]       cfg_dst_ip,
    input  logic [15:0]       cfg_src_port,
    input  logic [15:0]       cfg_dst_port,
    input  logic [LEN_W-1:0]  cfg_payload_bytes,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [WORD_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_sop,
    output logic              out_eop
);

    localparam int CNT_W = LEN_W - 2;
    localparam logic [CNT_W-1:0] LAST_HDR = CNT_W'(HDR_BEATS - 1);

    pkt_state_e        state_q;
    logic [CNT_W-1:0]  beat_q;
    logic [31:0]       seq_q;
    logic [31:0]       stamp_q;
    pkt_cfg_t          snap_q;
    pkt_cfg_t          cfg_now;
    logic [TS_W-1:0]   cycle_cnt;
    logic [CNT_W-1:0]  pay_words;
    logic [LEN_W-1:0]  pay_aligned;
    logic [15:0]       total_len;
    logic [15:0]       udp_len;
    logic [15:0]       ip_csum;
    logic [WORD_W-1:0] hdr_word;
    logic              in_hdr;
    logic              in_pay;
    logic              hdr_last;
    logic              pay_last;
    logic              beat_fire;
    logic              pkt_done;

    // Gather the live configuration into one snapshot-able record.
    always_comb begin
        cfg_now.src_ip    = cfg_src_ip;
        cfg_now.dst_ip    = cfg_dst_ip;
        cfg_now.src_port  = cfg_src_port;
        cfg_now.dst_port  = cfg_dst_port;
        cfg_now.pay_bytes = cfg_payload_bytes;
    end

    // Derive word count and length fields from the captured byte length.
    always_comb begin
        pay_words   = snap_q.pay_bytes[LEN_W-1:2];
        pay_aligned = {pay_words, 2'b00};
        total_len   = 16'(pay_aligned) + IP_LEN_OVH;
        udp_len     = 16'(pay_aligned) + UDP_LEN_OVH;
    end

    udp_pkt_cycle_counter #(
        .CNT_W (TS_W)
    ) u_cycle_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .count (cycle_cnt)
    );

    udp_pkt_ip_csum u_ip_csum (
        .total_len (total_len),
        .ident     (seq_q[15:0]),
        .src_ip    (snap_q.src_ip),
        .dst_ip    (snap_q.dst_ip),
        .csum      (ip_csum)
    );

    udp_pkt_hdr_mux u_hdr_mux (
        .beat      (beat_q[BEAT_IDX_W-1:0]),
        .cfg       (snap_q),
        .total_len (total_len),
        .udp_len   (udp_len),
        .ident     (seq_q[15:0]),
        .csum      (ip_csum),
        .stamp     (stamp_q),
        .seq       (seq_q),
        .word      (hdr_word)
    );

    // Decode the current phase and its terminal beats.
    always_comb begin
        in_hdr    = (state_q == ST_HDR);
        in_pay    = (state_q == ST_PAY);
        hdr_last  = in_hdr && (beat_q == LAST_HDR);
        pay_last  = in_pay && (beat_q == pay_words - CNT_W'(1));
        beat_fire = out_valid && out_ready;
        pkt_done  = beat_fire && out_eop;
    end

    // Drive the output bus: header words, or samples passed straight through.
    always_comb begin
        out_valid = in_hdr || (in_pay && in_valid);
        in_ready  = in_pay && out_ready;
        out_data  = in_pay ? in_data : hdr_word;
        out_sop   = in_hdr && (beat_q == '0);
        out_eop   = (hdr_last && (pay_words == '0)) || pay_last;
    end

    // Sequence the datagram phases, capture config, timestamp and sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
            seq_q   <= '0;
            stamp_q <= '0;
            snap_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cfg_enable) begin
                        snap_q  <= cfg_now;
                        beat_q  <= '0;
                        state_q <= ST_HDR;
                    end
                end
                ST_HDR: begin
                    if (out_ready) begin
                        if (beat_q == '0) begin
                            stamp_q <= 32'(cycle_cnt);
                        end
                        if (hdr_last && (pay_words != '0)) begin
                            beat_q  <= '0;
                            state_q <= ST_PAY;
                        end else if (!hdr_last) begin
                            beat_q <= beat_q + CNT_W'(1);
                        end
                    end
                end
                ST_PAY: begin
                    if (beat_fire && !pay_last) begin
                        beat_q <= beat_q + CNT_W'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase

            if (pkt_done) begin
                seq_q  <= seq_q + 32'd1;
                beat_q <= '0;
                if (cfg_enable) begin
                    snap_q  <= cfg_now;
                    state_q <= ST_HDR;
                end else begin
                    state_q <= ST_IDLE;
                end
            end
        end
    end

endmodule

// File: rtl/udp_stream_packetizer_sva.sv
// Checker for the UDP stream packetizer: handshake, framing and sequence rules.
module udp_stream_packetizer_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic        out_sop,
    input logic        out_eop,
    input logic [31:0] seq_q
);

    // R1: reset leaves the block quiet on both sides.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !in_ready));

    // R9: a stalled output never takes input.
    assert_stall_blocks_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_ready |-> !in_ready);

    // R9: an input word accepted is a word delivered in the same cycle.
    assert_no_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> (out_valid && out_ready));

    // R9: the first header beat never consumes input.
    assert_hdr_no_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_sop |-> !in_ready);

    // R9: a stalled start-of-packet is held.
    assert_sop_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sop && !out_ready) |=> (out_valid && out_sop));

    // R8: a datagram is never a single beat.
    assert_sop_not_eop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_sop && out_eop));

    // R7: completing a datagram advances the sequence by one.
    assert_seq_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_eop) |=> (seq_q == $past(seq_q) + 32'd1));

endmodule

bind udp_stream_packetizer udp_stream_packetizer_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .seq_q     (seq_q)
);

// File: tb/udp_stream_packetizer_tb.sv
// Scoreboard bench: driver tasks queue expected beats, a monitor compares.
module udp_stream_packetizer_tb;

    typedef struct {
        logic [31:0] data;
        bit          sop;
        bit          eop;
        bit          is_ts;
        bit          chk_b2b;
        int          rq;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b0;
    logic [31:0] cfg_src_ip = 32'h0A00_0001;
    logic [31:0] cfg_dst_ip = 32'hC0A8_0102;
    logic [15:0] cfg_src_port = 16'd5000;
    logic [15:0] cfg_dst_port = 16'd6000;
    logic [15:0] cfg_payload_bytes = 16'd16;
    logic [31:0] in_data = 32'hA000_0000;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] out_data;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic        out_sop;
    logic        out_eop;

    int          n_tests = 0;
    int          n_fail = 0;
    exp_t        exp_q[$];
    logic [31:0] bc = 32'd0;
    logic [31:0] ts_exp = 32'd0;
    logic [31:0] last_eop = 32'hFFFF_FFF0;
    int          sop_seen = 0;
    logic [31:0] exp_seq = 32'd0;
    logic [31:0] exp_word = 32'hA000_0000;
    logic [15:0] lfsr = 16'hACE1;
    bit          src_gaps = 1'b0;
    bit          snk_rand = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    udp_stream_packetizer u_dut (
        .clk               (clk),
        .rst_n             (rst_n),
        .cfg_enable        (cfg_enable),
        .cfg_src_ip        (cfg_src_ip),
        .cfg_dst_ip        (cfg_dst_ip),
        .cfg_src_port      (cfg_src_port),
        .cfg_dst_port      (cfg_dst_port),
        .cfg_payload_bytes (cfg_payload_bytes),
        .in_data           (in_data),
        .in_valid          (in_valid),
        .in_ready          (in_ready),
        .out_data          (out_data),
        .out_valid         (out_valid),
        .out_ready         (out_ready),
        .out_sop           (out_sop),
        .out_eop           (out_eop)
    );

    function automatic string req_name(int r);
        case (r)
            1: return "R1";   2: return "R2";   3: return "R3";
            4: return "R4";   5: return "R5";   6: return "R6";
            7: return "R7";   8: return "R8";   9: return "R9";
            10: return "R10"; 11: return "R11";
            default: return "R?";
        endcase
    endfunction

    // R3 reference: end-around-carry sum of header halves, inverted.
    function automatic logic [15:0] ref_csum(logic [31:0] w0, logic [31:0] w1,
                                             logic [31:0] w2, logic [31:0] w3,
                                             logic [31:0] w4);
        logic [31:0] s;
        s = 32'(w0[31:16]) + 32'(w0[15:0]) + 32'(w1[31:16]) + 32'(w1[15:0])
          + 32'(w2[31:16]) + 32'(w2[15:0]) + 32'(w3[31:16]) + 32'(w3[15:0])
          + 32'(w4[31:16]) + 32'(w4[15:0]);
        s = 32'(s[15:0]) + 32'(s[31:16]);
        s = 32'(s[15:0]) + 32'(s[31:16]);
        return ~s[15:0];
    endfunction

    task automatic fail_line(string rq, logic [31:0] act, logic [31:0] exp);
        n_fail++;
        $display("FAIL %s actual=%h expected=%h t=%0t", rq, act, exp, $time);
    endtask

    task automatic push(logic [31:0] d, bit s, bit e, bit ts, bit b2b, int rq);
        exp_t it;
        it.data = d; it.sop = s; it.eop = e; it.is_ts = ts;
        it.chk_b2b = b2b; it.rq = rq;
        exp_q.push_back(it);
    endtask

    // Driver: queue one expected datagram built from the requirements.
    task automatic push_packet(logic [31:0] sip, logic [31:0] dip,
                               logic [15:0] sp, logic [15:0] dp,
                               logic [15:0] plen, bit b2b, int addr_rq);
        logic [15:0] p;
        logic [31:0] w0, w1, w2;
        int nw;
        p  = {plen[15:2], 2'b00};                          // R4
        nw = int'(p) / 4;
        w0 = {8'h45, 8'h00, p + 16'd36};                  // R2 R4
        w1 = {exp_seq[15:0], 16'h0000};                   // R2
        w2 = {8'd64, 8'd17, 16'h0000};
        w2[15:0] = ref_csum(w0, w1, w2, sip, dip);        // R3
        push(w0, 1'b1, 1'b0, 1'b0, b2b, 4);
        push(w1, 1'b0, 1'b0, 1'b0, 1'b0, 2);
        push(w2, 1'b0, 1'b0, 1'b0, 1'b0, 3);
        push(sip, 1'b0, 1'b0, 1'b0, 1'b0, addr_rq);       // R5
        push(dip, 1'b0, 1'b0, 1'b0, 1'b0, addr_rq);
        push({sp, dp}, 1'b0, 1'b0, 1'b0, 1'b0, addr_rq);
        push({p + 16'd16, 16'h0000}, 1'b0, 1'b0, 1'b0, 1'b0, 4);
        push(32'd0, 1'b0, 1'b0, 1'b1, 1'b0, 6);           // R6
        push(exp_seq, 1'b0, nw == 0, 1'b0, 1'b0, 7);      // R7
        for (int k = 0; k < nw; k++) begin                // R8
            push(exp_word, 1'b0, k == nw - 1, 1'b0, 1'b0, 8);
            exp_word = exp_word + 32'd1;
        end
        exp_seq = exp_seq + 32'd1;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Run n datagrams with the current config, stopping on the last one.
    task automatic run_burst(int n, bit b2b);
        int base;
        base = sop_seen;
        for (int i = 0; i < n; i++)
            push_packet(cfg_src_ip, cfg_dst_ip, cfg_src_port, cfg_dst_port,
                        cfg_payload_bytes, b2b && (i > 0), 5);
        @(posedge clk); #1 cfg_enable = 1'b1;
        while (sop_seen < base + n) @(negedge clk);
        @(posedge clk); #1 cfg_enable = 1'b0;
        drain();
    endtask

    // Bench cycle reference for R6.
    always @(posedge clk) begin
        if (!rst_n) bc <= 32'd0;
        else        bc <= bc + 32'd1;
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end

    // Stream source: sequential words, optional gaps, held until taken.
    initial begin
        bit acc;
        forever begin
            @(negedge clk);
            acc = in_valid && in_ready;
            @(posedge clk); #1;
            if (acc) in_data = in_data + 32'd1;
            if (!in_valid || acc) in_valid = rst_n && (src_gaps ? lfsr[3] : 1'b1);
        end
    end

    // Sink ready pattern.
    initial begin
        forever begin
            @(posedge clk); #1;
            out_ready = snk_rand ? lfsr[7] : 1'b1;
        end
    end

    // Monitor: stall rules and scoreboard comparison.
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid && !out_ready) begin
                n_tests++;
                if (in_ready) fail_line("R9", {31'd0, in_ready}, 32'd0);
            end
            if (out_sop && out_valid) begin
                n_tests++;
                if (in_ready) fail_line("R9", {31'd0, in_ready}, 32'd0);
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    n_tests++;
                    fail_line("R10", out_data, 32'd0);    // beat with nothing pending
                end else begin
                    exp_t e;
                    logic [31:0] want;
                    e = exp_q.pop_front();
                    if (out_sop) begin
                        ts_exp = bc;
                        sop_seen++;
                    end
                    want = e.is_ts ? ts_exp : e.data;
                    n_tests++;
                    if (out_data !== want) fail_line(req_name(e.rq), out_data, want);
                    n_tests++;
                    if (out_sop !== e.sop || out_eop !== e.eop)
                        fail_line("R8", {30'd0, out_sop, out_eop}, {30'd0, e.sop, e.eop});
                    if (e.chk_b2b) begin
                        n_tests++;
                        if (bc != last_eop + 32'd1) fail_line("R11", bc, last_eop + 32'd1);
                    end
                    if (out_eop) last_eop = bc;
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired, %0d beats pending (expected 0)", exp_q.size());
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1: quiet during reset.
        repeat (3) @(negedge clk);
        n_tests++;
        if (out_valid !== 1'b0 || in_ready !== 1'b0)
            fail_line("R1", {30'd0, out_valid, in_ready}, 32'd0);
        @(posedge clk); #1 rst_n = 1'b1;
        // R1: quiet after reset while disabled.
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            n_tests++;
            if (out_valid !== 1'b0 || in_ready !== 1'b0)
                fail_line("R1", {30'd0, out_valid, in_ready}, 32'd0);
        end

        // R2..R8, R11: three back-to-back datagrams, 16-byte payload.
        cfg_payload_bytes = 16'd16;
        run_burst(3, 1'b1);

        // R8: zero payload, eop on the sequence beat.
        cfg_payload_bytes = 16'd0;
        run_burst(2, 1'b1);

        // R4: unaligned length, low bits ignored.
        cfg_payload_bytes = 16'd18;
        run_burst(2, 1'b1);

        // R9, R6: random stalls and input gaps.
        src_gaps = 1'b1;
        snk_rand = 1'b1;
        cfg_payload_bytes = 16'd20;
        cfg_src_port = 16'hBEEF;
        run_burst(4, 1'b0);
        src_gaps = 1'b0;
        snk_rand = 1'b0;

        // R10: change config mid-datagram, then drop enable mid-datagram.
        begin
            int base;
            base = sop_seen;
            cfg_payload_bytes = 16'd8;
            push_packet(cfg_src_ip, cfg_dst_ip, cfg_src_port, cfg_dst_port,
                        16'd8, 1'b0, 10);
            push_packet(32'h0102_0304, 32'hFFEE_DDCC, 16'd7, 16'd9,
                        16'd12, 1'b1, 10);
            @(posedge clk); #1 cfg_enable = 1'b1;
            while (sop_seen < base + 1) @(negedge clk);
            @(posedge clk); #1;
            cfg_src_ip = 32'h0102_0304;
            cfg_dst_ip = 32'hFFEE_DDCC;
            cfg_src_port = 16'd7;
            cfg_dst_port = 16'd9;
            cfg_payload_bytes = 16'd12;
            while (sop_seen < base + 2) @(negedge clk);
            @(posedge clk); #1 cfg_enable = 1'b0;
            drain();
            // R10: output stays quiet after the stop.
            for (int i = 0; i < 30; i++) begin
                @(negedge clk);
                n_tests++;
                if (out_valid !== 1'b0) fail_line("R10", {31'd0, out_valid}, 32'd0);
            end
        end

        n_tests++;
        if (exp_q.size() != 0) fail_line("R8", exp_q.size(), 32'd0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule